// File: doc/BRIEF.md
# Aged Free-Address Queue

This block keeps the addresses of recently released memory blocks and holds each one back from reuse until it has waited a minimum number of clock ticks. A release is offered on the free port: the address goes into an internal ring of entries together with the value of a free-running tick counter at that moment. An allocator asks for an address on the allocate port. It receives the oldest entry, and only when that entry's age, the current tick minus its stored stamp, has reached the hold time.

Because the oldest entry leaves first and must first age, no address is handed out twice within one hold window. Reuse is therefore spread over all released blocks and does not fall on the few that were freed last. An entry's address and stamp are written once, when it is queued, and are only read afterwards.

Top module: `aging_free_queue`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full` is 0 and `allocValid` is 0, and the tick counter starts at 0.
- R2: A `freeValid` cycle while `full` is 0 and no pop happens stores `freeAddr` and raises `count` by one on the following edge.
- R3: Addresses are handed out strictly in the order in which they were accepted.
- R4: An `allocReq` whose head entry has an age below `HOLD_TICKS` gives `allocValid` 0 in the next cycle and leaves `count` and the head unchanged.
- R5: An `allocReq` whose head entry has an age of at least `HOLD_TICKS` gives `allocValid` 1 and the head address on `allocAddr` in the next cycle, and lowers `count` by one.
- R6: `full` is 1 exactly when `count` equals `DEPTH`. A `freeValid` offered while `full` is 1 is dropped, even if a pop happens in the same cycle, and that address is never handed out.
- R7: An accepted push and a pop in the same cycle leave `count` unchanged.
- R8: Age is computed modulo 2^`TS_W` as (tick − stamp). The tick advances by one every cycle and may wrap without delaying an entry whose real age is below 2^`TS_W`.
- R9: An `allocReq` while `empty` is 1 gives `allocValid` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freeValid | input | 1 | Offer a released address |
| freeAddr | input | ADDR_W | Released address |
| allocReq | input | 1 | Request an aged address |
| allocValid | output | 1 | Registered: the request in the previous cycle was granted |
| allocAddr | output | ADDR_W | Granted address, meaningful while allocValid is 1 |
| full | output | 1 | Ring holds DEPTH entries |
| empty | output | 1 | Ring holds no entries |
| count | output | $clog2(DEPTH+1) | Number of queued entries |

## Verification
A request in cycle n is answered on `allocValid`/`allocAddr` after the edge that closes cycle n. `count`, `full` and `empty` change on that same edge, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. In the same step it updates its own model, which counts cycles since reset as the tick and stamps each push with that count, so each expected value is compared in the cycle where it first becomes visible. The hold gate is tested at its exact boundary: requests are made on every cycle around age `HOLD_TICKS`-1 and `HOLD_TICKS`, also across a tick wrap.

// File: rtl/aging_fq_pkg.sv
package aging_fq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fqStrobe_t;
endpackage

// File: rtl/aging_fq_ctrl.sv
module aging_fq_ctrl
  import aging_fq_pkg::*;
(
  input  logic       freeValid,
  input  logic       allocReq,
  input  logic       full,
  input  logic       empty,
  input  logic       headAged,
  output fqStrobe_t  strobe
);
  always_comb begin
    // Push is judged on the occupancy at the start of the cycle only.
    strobe.push = freeValid && !full;
    strobe.pop  = allocReq && !empty && headAged;
  end
endmodule

// File: rtl/aging_fq_datapath.sv
module aging_fq_datapath
  import aging_fq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH      = 8,
  parameter int TS_W       = 16,
  parameter int HOLD_TICKS = 1000,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  fqStrobe_t         strobe,
  input  logic [ADDR_W-1:0] freeAddr,
  output logic              headAged,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              allocValid,
  output logic [ADDR_W-1:0] allocAddr
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [TS_W-1:0]  HOLD_V   = TS_W'(HOLD_TICKS);

  logic [TS_W-1:0]   tick;
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [TS_W-1:0]   stampMem[DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [TS_W-1:0]   headAge;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Modular age: correct across a tick wrap while the real age < 2^TS_W.
  assign headAge  = tick - stampMem[rdPtr];
  assign headAged = (headAge >= HOLD_V);
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) tick <= '0;
    else       tick <= tick + 1'b1;
  end

  // Entry storage: written only when an entry is queued.
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr]  <= freeAddr;
      stampMem[wrPtr] <= tick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      allocValid <= 1'b0;
      allocAddr  <= '0;
    end else begin
      allocValid <= strobe.pop;
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) begin
        rdPtr     <= nextPtr(rdPtr);
        allocAddr <= addrMem[rdPtr];
      end
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/aging_free_queue.sv
module aging_free_queue
  import aging_fq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DEPTH      = 8,
  parameter int TS_W       = 16,
  parameter int HOLD_TICKS = 1000,
  localparam int CNT_W     = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeValid,
  input  logic [ADDR_W-1:0] freeAddr,
  input  logic              allocReq,
  output logic              allocValid,
  output logic [ADDR_W-1:0] allocAddr,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  fqStrobe_t strobe;
  logic      headAged;

  aging_fq_ctrl ctrl_i (
    .freeValid (freeValid),
    .allocReq  (allocReq),
    .full      (full),
    .empty     (empty),
    .headAged  (headAged),
    .strobe    (strobe)
  );

  aging_fq_datapath #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .TS_W(TS_W), .HOLD_TICKS(HOLD_TICKS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .freeAddr   (freeAddr),
    .headAged   (headAged),
    .full       (full),
    .empty      (empty),
    .count      (count),
    .allocValid (allocValid),
    .allocAddr  (allocAddr)
  );
endmodule

// File: rtl/aging_fq_checker.sv
module aging_fq_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rstN,
  input logic             freeValid,
  input logic             allocReq,
  input logic             allocValid,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] count
);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  p_full_refuse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && !allocReq) |=> (count == $past(count)));

  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allocValid) |-> $past(allocReq));

  p_empty_no_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    empty |=> !allocValid);

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && !full && !allocReq) |=> (count == $past(count) + 1'b1));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !$past(freeValid)) |-> (count < CNT_W'(DEPTH)));
endmodule

bind aging_free_queue aging_fq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .freeValid(freeValid), .allocReq(allocReq),
  .allocValid(allocValid), .full(full), .empty(empty), .count(count)
);

// File: tb/aging_free_queue_tb.sv
`timescale 1ns/1ps
module aging_free_queue_tb_top;
  localparam int AW = 16, DEPTH = 4, TS = 6, HOLD = 10;
  localparam int TMASK = (1 << TS) - 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic freeValid = 1'b0, allocReq = 1'b0;
  logic [AW-1:0] freeAddr = '0;
  logic allocValid, full, empty;
  logic [AW-1:0] allocAddr;
  logic [CW-1:0] count;

  int errors = 0, checks = 0, cyc = 0;
  int mA[DEPTH], mS[DEPTH];
  int mH = 0, mT = 0, mN = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  aging_free_queue #(.ADDR_W(AW), .DEPTH(DEPTH), .TS_W(TS), .HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .freeValid(freeValid), .freeAddr(freeAddr),
    .allocReq(allocReq), .allocValid(allocValid), .allocAddr(allocAddr),
    .full(full), .empty(empty), .count(count));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One cycle: drive at negedge, model the edge, sample 1 ns after it.
  task automatic step(input logic fv, input int fa, input logic ar, input string popTag);
    bit elig, doPop, doPush, wasFull;
    int popAddr;
    freeValid = fv; freeAddr = AW'(fa); allocReq = ar;
    elig    = (mN > 0) && (((cyc - mS[mH]) & TMASK) >= HOLD);
    doPop   = ar && elig;
    wasFull = (mN == DEPTH);
    doPush  = fv && !wasFull;
    popAddr = mA[mH];
    @(posedge clk); #1;
    if (doPop) begin mH = (mH + 1) % DEPTH; mN--; end
    if (doPush) begin mA[mT] = fa; mS[mT] = cyc; mT = (mT + 1) % DEPTH; mN++; end
    cyc++;
    if (!ar)            chk("R5 idle", int'(allocValid), 0);
    else if (mN == 0 && !doPop && !doPush) chk("R9", int'(allocValid), 0);
    else                chk(popTag, int'(allocValid), int'(doPop));
    if (doPop && allocValid) chk("R3 order", int'(allocAddr), popAddr);
    if (doPush && doPop)     chk("R7 count", int'(count), mN);
    else if (fv && wasFull)  chk("R6 refuse count", int'(count), mN);
    else                     chk("R2 count", int'(count), mN);
    chk("R6 full", int'(full), int'(mN == DEPTH));
    chk("R1 empty", int'(empty), int'(mN == 0));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 valid", int'(allocValid), 0);
    // R9 request on empty
    step(0, 0, 1, "R9");
    // R2 pushes, R4 early requests
    step(1, 'h11, 0, "R4");
    step(1, 'h22, 1, "R4");
    step(1, 'h33, 1, "R4");
    // R5/R3: request every cycle across the hold boundary
    for (int i = 0; i < 16; i++) step(0, 0, 1, "R5 aged");
    // R6: fill, push while full, drain
    for (int i = 0; i < DEPTH; i++) step(1, 'hA0 + i, 0, "R4");
    step(1, 'hBB, 0, "R6");
    step(1, 'hBC, 1, "R4");
    for (int i = 0; i < 12; i++) step(0, 0, 0, "R4");
    step(1, 'hBD, 1, "R6 full with pop");
    for (int i = 0; i < 20; i++) step(0, 0, 1, "R5 drain");
    // R7: push and pop in the same cycle
    step(1, 'hC0, 0, "R4");
    for (int i = 0; i < HOLD; i++) step(0, 0, 0, "R4");
    step(1, 'hC1, 1, "R7");
    for (int i = 0; i < 14; i++) step(0, 0, 1, "R5 drain");
    // R8: push just before the tick wraps, request every cycle
    while ((cyc & TMASK) != 60) step(0, 0, 0, "R4");
    step(1, 'hD0, 0, "R8");
    step(1, 'hD1, 1, "R8");
    for (int i = 0; i < 16; i++) step(0, 0, 1, "R8 wrap");
    // Mixed sweep driven by an LFSR
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], int'(lfsr[11:4]), lfsr[1] | lfsr[5], "R5 sweep");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule